// File: doc/BRIEF.md
# Protected Register Write Gate

This block guards a small bank of system configuration registers against stray software writes. It has two ports onto the bank: a processor register port and a debug port. The processor may write a protected register only while a global write-permission flag is set. The flag is clear after reset. A pulse on `grant_access` sets it and a pulse on `revoke_access` clears it. Debug writes do not depend on the flag. Reads from either port are always allowed.

A second layer of protection is a set of sticky per-register lock bits. They live in a lock word at the address just above the register bank. Writing a 1 to a bit locks the matching register until the next reset. The lockable set is chosen by a parameter; by default it covers the clock configuration and peripheral clock enable registers at addresses 0 and 1. A write that the gate refuses leaves the bank unchanged and raises a one-cycle `violation` pulse, so tests can see that the write was refused.

Top module: `prg_write_gate`

## Requirements
- R1: After synchronous reset the following hold. Every register holds `RST_VAL` (default 0), all lock bits are 0, the write-permission flag is 0, `violation` is 0, and both read-data outputs are 0.
- R2: While the flag is 0, a processor write to a protected register (bit set in `PROT_MASK`, default all but register 7) leaves it unchanged.
- R3: `grant_access` sets the flag and `revoke_access` clears it. The change takes effect for writes in the following cycle. When both are high in the same cycle, the flag ends up 0.
- R4: A debug write to an unlocked register takes effect in the next cycle, whatever the flag value.
- R5: Either port's read data, one cycle after its read strobe, shows the following: register i at address i, the lock word at address `NUM_REGS` (8 by default, bit i = lock of register i), and 0 at any other address. Without a strobe the read data holds. Reads are allowed whatever the flag value.
- R6: A write to the lock word ORs its data into the lock bits. Writing 0 clears nothing. Bits outside `LOCK_MASK` (default 0x03) stay 0. Processor writes to the lock word obey the flag; debug writes do not.
- R7: A locked register ignores processor writes even while the flag is 1. It also ignores debug writes, unless `DBG_LOCK_BYPASS` is set (default 0).
- R8: A refused write to an address in range (0 to `NUM_REGS`) raises `violation` for exactly the next cycle. This applies to either port.
- R9: When both ports write the same address in the same cycle, the debug write wins. The discarded processor write raises no violation.
- R10: A register outside `PROT_MASK` accepts processor writes while the flag is 0, unless it is locked.
- R11: Writes to addresses above `NUM_REGS` change nothing and raise no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | Processor register address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_rdata | output | DATA_W | Processor read data, registered |
| dbg_addr | input | ADDR_W | Debug register address |
| dbg_wdata | input | DATA_W | Debug write data |
| dbg_wr | input | 1 | Debug write strobe |
| dbg_rd | input | 1 | Debug read strobe |
| dbg_rdata | output | DATA_W | Debug read data, registered |
| grant_access | input | 1 | Set the write-permission flag |
| revoke_access | input | 1 | Clear the write-permission flag |
| reg_q | output | NUM_REGS*DATA_W | Register contents, register i in bits i*DATA_W upward |
| violation | output | 1 | One-cycle pulse after a refused write |

## Verification
The hardest case to reach is a register that is locked while the flag is 1. The bench first sets a lock bit through the debug port, then grants access. It then shows that neither port can change the register, and that both refusals pulse `violation`. A processor write and a debug write to the same address in the same cycle is just as rare under random traffic. So the directed part drives that collision twice: once with the processor write allowed and once with it refused. Random traffic, with the address drawn over the register bank, the lock word and one unmapped address, then mixes flag changes, lock growth and reads over two reset epochs.

// File: rtl/prg_pkg.sv
package prg_pkg;

    typedef enum logic [1:0] {
        WV_IDLE   = 2'd0,
        WV_COMMIT = 2'd1,
        WV_BLOCK  = 2'd2
    } wr_verdict_e;

    // Decide the fate of one write attempt from one port.
    function automatic wr_verdict_e judge_write(
        input logic wr,
        input logic in_range,
        input logic obey_flag,
        input logic flag,
        input logic locked,
        input logic lock_bypass
    );
        if (!wr || !in_range)         return WV_IDLE;
        if (locked && !lock_bypass)   return WV_BLOCK;
        if (obey_flag && !flag)       return WV_BLOCK;
        return WV_COMMIT;
    endfunction

endpackage

// File: rtl/prg_access_flag.sv
module prg_access_flag (
    input  logic clk,
    input  logic rst,
    input  logic grant,
    input  logic revoke,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (rst)         flag_q <= 1'b0;
        else if (revoke) flag_q <= 1'b0;
        else if (grant)  flag_q <= 1'b1;
    end
endmodule

// File: rtl/prg_port_judge.sv
module prg_port_judge
    import prg_pkg::*;
#(
    parameter int          NUM_REGS        = 8,
    parameter int          ADDR_W          = 4,
    parameter logic [NUM_REGS-1:0] PROT_MASK = '1,
    parameter bit          IS_DEBUG        = 1'b0,
    parameter bit          DBG_LOCK_BYPASS = 1'b0
) (
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                flag,
    input  logic [NUM_REGS-1:0] lock_q,
    output logic [NUM_REGS-1:0] reg_commit,
    output logic                lock_commit,
    output logic                blocked
);
    localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(NUM_REGS);

    logic [NUM_REGS-1:0] hit;
    logic                is_reg, is_lock, locked, prot, obey, bypass;
    wr_verdict_e         verdict;

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            hit[i] = (addr == ADDR_W'(i));
        end
    end

    assign is_reg  = |hit;
    assign is_lock = (addr == LOCK_ADDR);
    assign locked  = |(hit & lock_q);
    assign prot    = |(hit & PROT_MASK);

    generate
        if (IS_DEBUG) begin : g_dbg
            assign obey   = 1'b0;
            assign bypass = DBG_LOCK_BYPASS;
        end else begin : g_cpu
            assign obey   = is_lock | prot;
            assign bypass = 1'b0;
        end
    endgenerate

    assign verdict     = judge_write(wr, is_reg | is_lock, obey, flag,
                                     is_reg & locked, bypass);
    assign reg_commit  = hit & {NUM_REGS{verdict == WV_COMMIT}};
    assign lock_commit = is_lock && (verdict == WV_COMMIT);
    assign blocked     = (verdict == WV_BLOCK);
endmodule

// File: rtl/prg_reg_bank.sv
module prg_reg_bank #(
    parameter int                NUM_REGS = 8,
    parameter int                DATA_W   = 16,
    parameter logic [DATA_W-1:0] RST_VAL  = '0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_REGS-1:0]          cpu_commit,
    input  logic [NUM_REGS-1:0]          dbg_commit,
    input  logic [DATA_W-1:0]            cpu_wdata,
    input  logic [DATA_W-1:0]            dbg_wdata,
    output logic [NUM_REGS*DATA_W-1:0]   regs_flat
);
    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)                regs_flat[g*DATA_W +: DATA_W] <= RST_VAL;
                else if (dbg_commit[g]) regs_flat[g*DATA_W +: DATA_W] <= dbg_wdata;
                else if (cpu_commit[g]) regs_flat[g*DATA_W +: DATA_W] <= cpu_wdata;
            end
        end
    endgenerate
endmodule

// File: rtl/prg_lock_bank.sv
module prg_lock_bank #(
    parameter int                  NUM_REGS  = 8,
    parameter logic [NUM_REGS-1:0] LOCK_MASK = '1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cpu_commit,
    input  logic                dbg_commit,
    input  logic [NUM_REGS-1:0] cpu_bits,
    input  logic [NUM_REGS-1:0] dbg_bits,
    output logic [NUM_REGS-1:0] lock_q
);
    logic [NUM_REGS-1:0] set_bits;

    always_comb begin
        if (dbg_commit)      set_bits = dbg_bits;
        else if (cpu_commit) set_bits = cpu_bits;
        else                 set_bits = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) lock_q <= '0;
        else     lock_q <= lock_q | (set_bits & LOCK_MASK);
    end
endmodule

// File: rtl/prg_read_port.sv
module prg_read_port #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rd,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
    input  logic [NUM_REGS-1:0]        lock_q,
    output logic [DATA_W-1:0]          rdata
);
    logic [DATA_W-1:0] sel;

    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == ADDR_W'(i)) sel = regs_flat[i*DATA_W +: DATA_W];
        end
        if (addr == ADDR_W'(NUM_REGS)) sel = DATA_W'(lock_q);
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= sel;
    end
endmodule

// File: rtl/prg_write_gate.sv
module prg_write_gate #(
    parameter int                  NUM_REGS        = 8,
    parameter int                  DATA_W          = 16,
    parameter int                  ADDR_W          = $clog2(NUM_REGS + 2),
    parameter logic [NUM_REGS-1:0] PROT_MASK       = 8'h7F,
    parameter logic [NUM_REGS-1:0] LOCK_MASK       = 8'h03,
    parameter bit                  DBG_LOCK_BYPASS = 1'b0,
    parameter logic [DATA_W-1:0]   RST_VAL         = '0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          cpu_addr,
    input  logic [DATA_W-1:0]          cpu_wdata,
    input  logic                       cpu_wr,
    input  logic                       cpu_rd,
    output logic [DATA_W-1:0]          cpu_rdata,
    input  logic [ADDR_W-1:0]          dbg_addr,
    input  logic [DATA_W-1:0]          dbg_wdata,
    input  logic                       dbg_wr,
    input  logic                       dbg_rd,
    output logic [DATA_W-1:0]          dbg_rdata,
    input  logic                       grant_access,
    input  logic                       revoke_access,
    output logic [NUM_REGS*DATA_W-1:0] reg_q,
    output logic                       violation
);
    logic                flag_q;
    logic [NUM_REGS-1:0] lock_q;
    logic [NUM_REGS-1:0] cpu_reg_c, dbg_reg_c, cpu_reg_eff;
    logic                cpu_lock_c, dbg_lock_c, cpu_lock_eff;
    logic                cpu_blk, dbg_blk, collide;

    prg_access_flag i_flag (
        .clk(clk), .rst(rst), .grant(grant_access), .revoke(revoke_access),
        .flag_q(flag_q)
    );

    prg_port_judge #(
        .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .PROT_MASK(PROT_MASK),
        .IS_DEBUG(1'b0), .DBG_LOCK_BYPASS(DBG_LOCK_BYPASS)
    ) i_cpu_judge (
        .wr(cpu_wr), .addr(cpu_addr), .flag(flag_q), .lock_q(lock_q),
        .reg_commit(cpu_reg_c), .lock_commit(cpu_lock_c), .blocked(cpu_blk)
    );

    prg_port_judge #(
        .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .PROT_MASK(PROT_MASK),
        .IS_DEBUG(1'b1), .DBG_LOCK_BYPASS(DBG_LOCK_BYPASS)
    ) i_dbg_judge (
        .wr(dbg_wr), .addr(dbg_addr), .flag(flag_q), .lock_q(lock_q),
        .reg_commit(dbg_reg_c), .lock_commit(dbg_lock_c), .blocked(dbg_blk)
    );

    // Debug wins a same-address collision; the processor write is dropped.
    assign collide      = cpu_wr && dbg_wr && (cpu_addr == dbg_addr);
    assign cpu_reg_eff  = collide ? '0 : cpu_reg_c;
    assign cpu_lock_eff = cpu_lock_c && !collide;

    prg_reg_bank #(
        .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .RST_VAL(RST_VAL)
    ) i_regs (
        .clk(clk), .rst(rst), .cpu_commit(cpu_reg_eff), .dbg_commit(dbg_reg_c),
        .cpu_wdata(cpu_wdata), .dbg_wdata(dbg_wdata), .regs_flat(reg_q)
    );

    prg_lock_bank #(
        .NUM_REGS(NUM_REGS), .LOCK_MASK(LOCK_MASK)
    ) i_locks (
        .clk(clk), .rst(rst), .cpu_commit(cpu_lock_eff), .dbg_commit(dbg_lock_c),
        .cpu_bits(cpu_wdata[NUM_REGS-1:0]), .dbg_bits(dbg_wdata[NUM_REGS-1:0]),
        .lock_q(lock_q)
    );

    prg_read_port #(
        .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) i_cpu_rd (
        .clk(clk), .rst(rst), .rd(cpu_rd), .addr(cpu_addr),
        .regs_flat(reg_q), .lock_q(lock_q), .rdata(cpu_rdata)
    );

    prg_read_port #(
        .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) i_dbg_rd (
        .clk(clk), .rst(rst), .rd(dbg_rd), .addr(dbg_addr),
        .regs_flat(reg_q), .lock_q(lock_q), .rdata(dbg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) violation <= 1'b0;
        else     violation <= (cpu_blk && !collide) || dbg_blk;
    end
endmodule

// File: rtl/prg_write_gate_chk.sv
module prg_write_gate_chk #(
    parameter int                  NUM_REGS        = 8,
    parameter int                  DATA_W          = 16,
    parameter int                  ADDR_W          = 4,
    parameter logic [NUM_REGS-1:0] PROT_MASK       = '1,
    parameter logic [NUM_REGS-1:0] LOCK_MASK       = '1,
    parameter bit                  DBG_LOCK_BYPASS = 1'b0
) (
    input logic                       clk,
    input logic                       rst,
    input logic [ADDR_W-1:0]          cpu_addr,
    input logic                       cpu_wr,
    input logic [ADDR_W-1:0]          dbg_addr,
    input logic                       dbg_wr,
    input logic                       grant_access,
    input logic                       revoke_access,
    input logic [NUM_REGS*DATA_W-1:0] reg_q,
    input logic                       violation,
    input logic                       flag_q,
    input logic [NUM_REGS-1:0]        lock_q
);
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!violation && !flag_q && lock_q == '0)); // R1

    AST_REVOKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        revoke_access |=> !flag_q); // R3

    AST_GRANT_SETS: assert property (@(posedge clk) disable iff (rst)
        (grant_access && !revoke_access) |=> flag_q); // R3

    AST_LOCKS_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q))); // R6

    AST_LOCKS_MASKED: assert property (@(posedge clk) disable iff (rst)
        (lock_q & ~LOCK_MASK) == '0); // R6

    AST_VIOL_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        violation |-> $past(cpu_wr || dbg_wr)); // R8

    genvar k;
    generate
        for (k = 0; k < NUM_REGS; k++) begin : g_chk
            if (PROT_MASK[k]) begin : g_prot
                AST_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (rst)
                    (!flag_q && cpu_wr && cpu_addr == ADDR_W'(k) &&
                     !(dbg_wr && dbg_addr == ADDR_W'(k)))
                    |=> $stable(reg_q[k*DATA_W +: DATA_W])); // R2
            end
            if (LOCK_MASK[k]) begin : g_lock
                AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
                    (lock_q[k] && !(DBG_LOCK_BYPASS && dbg_wr))
                    |=> $stable(reg_q[k*DATA_W +: DATA_W])); // R7
            end
        end
    endgenerate
endmodule

bind prg_write_gate prg_write_gate_chk #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .PROT_MASK(PROT_MASK), .LOCK_MASK(LOCK_MASK), .DBG_LOCK_BYPASS(DBG_LOCK_BYPASS)
) i_chk (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .dbg_addr(dbg_addr), .dbg_wr(dbg_wr), .grant_access(grant_access),
    .revoke_access(revoke_access), .reg_q(reg_q), .violation(violation),
    .flag_q(flag_q), .lock_q(lock_q)
);

// File: tb/test_prg_write_gate.sv
module test_prg_write_gate;
    localparam int N  = 8;
    localparam int DW = 16;
    localparam int AW = 4;
    localparam logic [N-1:0] PROT = 8'h7F;
    localparam logic [N-1:0] LMSK = 8'h03;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] cpu_addr, dbg_addr;
    logic [DW-1:0] cpu_wdata, dbg_wdata, cpu_rdata, dbg_rdata;
    logic          cpu_wr, cpu_rd, dbg_wr, dbg_rd, grant_access, revoke_access;
    logic [N*DW-1:0] reg_q;
    logic          violation;

    prg_write_gate i_prg_write_gate (
        .clk(clk), .rst(rst),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_rdata(cpu_rdata),
        .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_wr(dbg_wr), .dbg_rd(dbg_rd),
        .dbg_rdata(dbg_rdata),
        .grant_access(grant_access), .revoke_access(revoke_access),
        .reg_q(reg_q), .violation(violation)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [DW-1:0] m_reg [N];
    logic [N-1:0]  m_lock;
    logic          m_flag, m_viol;
    logic [DW-1:0] m_crd, m_drd;

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        for (int i = 0; i < N; i++)
            check(tag, $sformatf("reg%0d", i), reg_q[i*DW +: DW], m_reg[i]);
        check(tag, "violation", DW'(violation), DW'(m_viol));
        check(tag, "cpu_rdata", cpu_rdata, m_crd);
        check(tag, "dbg_rdata", dbg_rdata, m_drd);
    endtask

    function automatic logic [DW-1:0] m_read(input logic [AW-1:0] a);
        if (a < N)       return m_reg[a];
        else if (a == N) return DW'(m_lock);
        else             return '0;
    endfunction

    task automatic idle();
        cpu_addr = '0; cpu_wdata = '0; cpu_wr = 0; cpu_rd = 0;
        dbg_addr = '0; dbg_wdata = '0; dbg_wr = 0; dbg_rd = 0;
        grant_access = 0; revoke_access = 0;
    endtask

    // Apply the current inputs for one clock and compare at the next falling edge.
    task automatic step(input string tag);
        logic [DW-1:0] nreg [N];
        logic [N-1:0]  nlock;
        logic cblk, dblk, coll, cin, din;
        for (int i = 0; i < N; i++) nreg[i] = m_reg[i];
        nlock = m_lock;
        cblk = 0; dblk = 0;
        coll = cpu_wr && dbg_wr && (cpu_addr == dbg_addr);
        cin  = cpu_addr <= N;
        din  = dbg_addr <= N;
        if (cpu_wr && cin) begin
            if (cpu_addr < N) cblk = m_lock[cpu_addr] || (PROT[cpu_addr] && !m_flag);
            else              cblk = !m_flag;
            if (!cblk && !coll) begin
                if (cpu_addr < N) nreg[cpu_addr] = cpu_wdata;
                else              nlock = nlock | (cpu_wdata[N-1:0] & LMSK);
            end
        end
        if (dbg_wr && din) begin
            if (dbg_addr < N) dblk = m_lock[dbg_addr];
            if (!dblk) begin
                if (dbg_addr < N) nreg[dbg_addr] = dbg_wdata;
                else              nlock = nlock | (dbg_wdata[N-1:0] & LMSK);
            end
        end
        if (cpu_rd) m_crd = m_read(cpu_addr);
        if (dbg_rd) m_drd = m_read(dbg_addr);
        m_viol = (cblk && !coll) || dblk;
        if (revoke_access)     m_flag = 0;
        else if (grant_access) m_flag = 1;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < N; i++) m_reg[i] = nreg[i];
        m_lock = nlock;
        compare(tag);
        idle();
    endtask

    task automatic do_reset();
        idle();
        rst = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        for (int i = 0; i < N; i++) m_reg[i] = '0;
        m_lock = '0; m_flag = 0; m_viol = 0; m_crd = '0; m_drd = '0;
        compare("R1");
    endtask

    task automatic cw(input logic [AW-1:0] a, input logic [DW-1:0] d);
        cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    endtask
    task automatic dw(input logic [AW-1:0] a, input logic [DW-1:0] d);
        dbg_wr = 1; dbg_addr = a; dbg_wdata = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        @(negedge clk);
        do_reset();

        // R2: closed flag blocks protected write, R8 pulse then clears
        cw(2, 16'hAAAA); step("R2");
        step("R8");
        // R3: grant and revoke together leave the flag clear
        grant_access = 1; revoke_access = 1; step("R3");
        cw(2, 16'h1111); step("R3");
        grant_access = 1; step("R3");
        cw(2, 16'h1234); step("R3");
        revoke_access = 1; step("R3");
        cw(2, 16'h5555); step("R3");
        // R4: debug write with flag clear
        dw(3, 16'hBEEF); step("R4");
        // R5: reads on both ports, then hold without strobe
        cpu_rd = 1; cpu_addr = 3; dbg_rd = 1; dbg_addr = 2; step("R5");
        step("R5");
        // R10: unprotected register with flag clear
        cw(7, 16'h7777); step("R10");
        // R11: unmapped address writes and reads
        cw(12, 16'hFFFF); dw(9, 16'hFFFF); step("R11");
        cpu_rd = 1; cpu_addr = 12; step("R11");
        // R6: lock setting, zero writes, mask, CPU lock write while closed
        dw(8, 16'h0081); step("R6");
        dw(8, 16'h0000); step("R6");
        cw(8, 16'h0002); step("R6");
        dbg_rd = 1; dbg_addr = 8; step("R6");
        // R7: locked register with flag open refuses both ports
        grant_access = 1; step("R7");
        cw(0, 16'hC0DE); step("R7");
        dw(0, 16'hD0DE); step("R7");
        cw(1, 16'h0101); step("R7");
        // R9: collisions, debug wins
        cw(4, 16'h4444); dw(4, 16'h9999); step("R9");
        cw(0, 16'h4444); dw(4, 16'h2222); step("R9");
        revoke_access = 1; step("R9");
        cw(5, 16'h1212); dw(5, 16'h3434); step("R9");
        cpu_rd = 1; cpu_addr = 5; step("R9");

        for (int ep = 0; ep < 2; ep++) begin
            do_reset();
            for (int n = 0; n < 1500; n++) begin
                cpu_wr = ($urandom % 2) == 0;
                cpu_rd = ($urandom % 2) == 0;
                cpu_addr = AW'($urandom % 10);
                cpu_wdata = DW'($urandom);
                dbg_wr = ($urandom % 4) == 0;
                dbg_rd = ($urandom % 3) == 0;
                dbg_addr = AW'($urandom % 10);
                dbg_wdata = DW'($urandom);
                if (dbg_addr == N && ($urandom % 4) != 0) dbg_wdata = '0;
                if (cpu_addr == N && ($urandom % 4) != 0) cpu_wdata = '0;
                grant_access  = ($urandom % 10) == 0;
                revoke_access = ($urandom % 12) == 0;
                step("R2 R4 R5 R6 R7 R8 R9 R10 R11");
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule